// File: doc/BRIEF.md
# UART Receive Deframer

This block recovers characters from an asynchronous serial receive line. A 16x oversampling tick, generated elsewhere, paces the receiver. A falling edge on the line starts a candidate frame. The candidate is accepted as a start bit only if the line is still low eight ticks later. Every later bit is then sampled once at its centre, sixteen ticks after the previous sample.

Line settings come in on static configuration inputs:

- the number of data bits, five to eight;
- whether a parity bit is present;
- odd or even parity;
- whether parity is held at a fixed value instead of being computed;
- whether the transmitter sends one or two stop bits;
- queue mode or single-character mode.

Each completed character is stored together with four flags: framing error, parity error, break and overrun. Characters leave through a ready/valid port. In queue mode, storage holds `DEPTH` characters. In single-character mode, storage shrinks to one holding slot. Configuration is expected to stay constant while a frame is being received.

Top module: `uart_rx_deframer`

## Requirements
- R1: `cfg_wlen` selects the data length: 2'b00 is 5 bits, 2'b01 is 6, 2'b10 is 7, 2'b11 is 8. Data bits are received least significant first. `m_data` carries them in its low bits, and every unused upper bit reads 0.
- R2: A low level seen on a tick while idle starts a candidate frame, and that tick counts as tick 1. If the line is high on tick 8, the candidate is dropped, nothing is stored, and the receiver returns to idle.
- R3: With `cfg_par_en`=1 and `cfg_stick`=0, one parity bit follows the data. When `cfg_even`=0, the data bits plus the parity bit must hold an odd number of ones. When `cfg_even`=1, they must hold an even number. Any other value sets `m_perr`.
- R4: With `cfg_par_en`=1 and `cfg_stick`=1, the parity bit must be 1 when `cfg_even`=0 and 0 when `cfg_even`=1. Any other value sets `m_perr`.
- R5: With `cfg_par_en`=0, no parity bit is expected, the stop bit directly follows the data, and `m_perr` is 0. In that case `cfg_even` and `cfg_stick` have no effect.
- R6: If the stop bit is sampled low, `m_ferr` is set. The receiver then ignores the line until it has returned high.
- R7: Only the first stop bit is checked. `cfg_two_stop` has no effect, so a start bit placed right after the first stop bit is received normally.
- R8: `m_brk` is set when every data bit, the parity bit (if enabled) and the stop bit are all low. Such a character also carries `m_ferr`.
- R9: With `cfg_fifo_en`=1, up to `DEPTH` characters are stored and delivered in arrival order. A character is removed in each cycle where `m_valid` and `m_ready` are both 1.
- R10: With `cfg_fifo_en`=0, only one character is held. A second character that arrives before the first is taken counts as an overrun.
- R11: A character that completes while storage is full is discarded. The next character that is stored carries `m_ovr`=1, and later characters carry `m_ovr`=0.
- R12: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and the data and flags hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_wlen | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_even | input | 1 | Even parity select, also selects the stick value |
| cfg_stick | input | 1 | Fixed-value parity |
| cfg_two_stop | input | 1 | Two stop bits sent by the peer (not checked) |
| cfg_fifo_en | input | 1 | 1 = queue of DEPTH entries, 0 = single slot |
| m_valid | output | 1 | A character is available |
| m_ready | input | 1 | Consumer accepts the character |
| m_data | output | 8 | Received data, zero padded |
| m_ferr | output | 1 | Stop bit was low |
| m_perr | output | 1 | Parity mismatch |
| m_brk | output | 1 | Break detected |
| m_ovr | output | 1 | One or more characters were lost before this one |

## Verification
A character is stored on the clock edge that takes its stop-bit sample, on tick 8 of the stop bit, so `m_valid` rises one cycle later. The bench waits for the rest of the stop bit plus an idle bit before it looks at the output, which keeps every check well clear of that edge. A pop takes effect at the single rising edge for which the bench holds `m_ready` high. The bench samples outputs on falling edges, so each value it reads is the one settled after the preceding rising edge. False-start checks read `m_valid` a full bit time after the glitch, once a wrongly accepted frame would already have moved past its start.

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_even,
  input  logic       cfg_stick,
  input  logic       cfg_two_stop,
  input  logic       cfg_fifo_en,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_ferr,
  output logic       m_perr,
  output logic       m_brk,
  output logic       m_ovr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 12;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITH} st_t;

  st_t          st;
  logic [3:0]   cnt;
  logic [2:0]   bidx;
  logic [7:0]   shreg;
  logic         pbit, perr_r;
  logic         ovr_pend;
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr, rd;
  logic [CW-1:0] count;

  logic [2:0] last_idx;
  logic       mid, fin, full, push, pop;
  logic       brk_now;

  assign last_idx = 3'(cfg_wlen) + 3'd4;
  assign mid      = tick && (cnt == 4'd15);
  assign fin      = (st == S_STOP) && mid;
  assign brk_now  = !rxd && (shreg == 8'd0) && !pbit;
  assign full     = cfg_fifo_en ? (count == CW'(DEPTH)) : (count != '0);
  assign push     = fin && !full;
  assign pop      = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      shreg  <= '0;
      pbit   <= 1'b0;
      perr_r <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE:
          if (tick && !rxd) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (tick) begin
            if (cnt == 4'd6) begin
              cnt <= '0;
              if (!rxd) begin
                st     <= S_DATA;
                bidx   <= '0;
                shreg  <= '0;
                pbit   <= 1'b0;
                perr_r <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
        S_DATA:
          if (tick) begin
            if (mid) begin
              cnt         <= '0;
              shreg[bidx] <= rxd;
              bidx        <= bidx + 3'd1;
              if (bidx == last_idx) st <= cfg_par_en ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
        S_PAR:
          if (tick) begin
            if (mid) begin
              cnt    <= '0;
              pbit   <= rxd;
              perr_r <= cfg_stick ? (rxd == cfg_even) : ((^shreg ^ rxd) == cfg_even);
              st     <= S_STOP;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
        S_STOP:
          if (tick) begin
            if (mid) begin
              cnt <= '0;
              st  <= rxd ? S_IDLE : S_WAITH;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
        S_WAITH:
          if (rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr       <= '0;
      rd       <= '0;
      count    <= '0;
      ovr_pend <= 1'b0;
    end else begin
      if (push) begin
        mem[wr]  <= {ovr_pend, brk_now, perr_r, !rxd, shreg};
        wr       <= (wr == AW'(DEPTH - 1)) ? '0 : wr + AW'(1);
        ovr_pend <= 1'b0;
      end else if (fin) begin
        ovr_pend <= 1'b1;
      end
      if (pop) rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + AW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign m_valid = (count != '0);
  assign {m_ovr, m_brk, m_perr, m_ferr, m_data} = mem[rd];

  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && cnt == 4'd6 && rxd) |=> (st == S_IDLE)) else $error("false start"); // R2
  AST_LOW_STOP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !rxd) |=> (st == S_WAITH)) else $error("low stop"); // R6
  AST_ONE_STOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rxd && cfg_two_stop) |=> (st == S_IDLE)) else $error("second stop"); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)) else $error("overflow"); // R9
  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && m_valid && !m_ready && fin) |=> (count == $past(count))) else $error("slot"); // R10
  AST_OVR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && full) |=> ovr_pend) else $error("overrun mark"); // R11
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable({m_ovr, m_brk, m_perr, m_ferr}))) else $error("hold"); // R12
endmodule

// File: tb/uart_rx_deframer_tb.sv
module uart_rx_deframer_tb;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_wlen = 2'b11;
  logic cfg_par_en = 1'b0, cfg_even = 1'b0, cfg_stick = 1'b0, cfg_two_stop = 1'b0, cfg_fifo_en = 1'b1;
  logic m_valid, m_ready = 1'b0;
  logic [7:0] m_data;
  logic m_ferr, m_perr, m_brk, m_ovr;

  int checks = 0, errors = 0;
  logic tdiv = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv <= ~tdiv;
    tick <= tdiv;
  end

  uart_rx_deframer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
    .cfg_stick(cfg_stick), .cfg_two_stop(cfg_two_stop), .cfg_fifo_en(cfg_fifo_en),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_ferr(m_ferr), .m_perr(m_perr), .m_brk(m_brk), .m_ovr(m_ovr)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (tick) k++;
    end
  endtask

  function automatic logic [7:0] mask_data(input logic [7:0] d, input logic [1:0] wl);
    return d & (8'hFF >> (3 - wl));
  endfunction

  function automatic logic good_par(input logic [7:0] d);
    if (cfg_stick) return ~cfg_even;
    return cfg_even ? ^d : ~^d;
  endfunction

  function automatic logic [11:0] expect_entry(input logic [7:0] d, input logic badpar,
                                               input logic stopv, input logic ovr);
    logic [7:0] md;
    logic pb, perr, brk;
    md   = mask_data(d, cfg_wlen);
    pb   = cfg_par_en ? (good_par(md) ^ badpar) : 1'b0;
    perr = cfg_par_en & badpar;
    brk  = !stopv && (md == 8'd0) && !pb;
    return {ovr, brk, perr, !stopv, md};
  endfunction

  task automatic send(input logic [7:0] d, input logic badpar, input logic stopv, input bit gap);
    logic [7:0] md;
    md = mask_data(d, cfg_wlen);
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 5 + cfg_wlen; i++) begin
      rxd = md[i];
      wait_ticks(16);
    end
    if (cfg_par_en) begin
      rxd = good_par(md) ^ badpar;
      wait_ticks(16);
    end
    rxd = stopv;
    wait_ticks(16);
    rxd = 1'b1;
    if (gap) wait_ticks(16);
  endtask

  task automatic pop_check(input string req, input logic [11:0] exp);
    @(negedge clk);
    check({req, " valid"}, {11'd0, m_valid}, 12'd1);
    check(req, {m_ovr, m_brk, m_perr, m_ferr, m_data}, exp);
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic check_empty(input string req);
    @(negedge clk);
    check(req, {11'd0, m_valid}, 12'd0);
  endtask

  logic [11:0] exp_q [$];

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check_empty("R12 reset empty");

    // R1: each data length, LSB first, zero padded
    for (int w = 0; w < 4; w++) begin
      cfg_wlen = 2'(w);
      send(8'hB5, 1'b0, 1'b1, 1'b1);
      pop_check("R1 length", expect_entry(8'hB5, 1'b0, 1'b1, 1'b0));
    end

    // R2: glitch shorter than half a bit
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(40);
    check_empty("R2 false start");

    // R3: odd and even parity, good and bad
    cfg_par_en = 1'b1;
    for (int e = 0; e < 2; e++) begin
      cfg_even = 1'(e);
      send(8'h3C, 1'b0, 1'b1, 1'b1);
      pop_check("R3 parity good", expect_entry(8'h3C, 1'b0, 1'b1, 1'b0));
      send(8'h3D, 1'b1, 1'b1, 1'b1);
      pop_check("R3 parity bad", expect_entry(8'h3D, 1'b1, 1'b1, 1'b0));
    end

    // R4: stick parity
    cfg_stick = 1'b1;
    for (int e = 0; e < 2; e++) begin
      cfg_even = 1'(e);
      send(8'h81, 1'b0, 1'b1, 1'b1);
      pop_check("R4 stick good", expect_entry(8'h81, 1'b0, 1'b1, 1'b0));
      send(8'h81, 1'b1, 1'b1, 1'b1);
      pop_check("R4 stick bad", expect_entry(8'h81, 1'b1, 1'b1, 1'b0));
    end

    // R5: parity disabled, stick/even ignored
    cfg_par_en = 1'b0;
    send(8'h5A, 1'b0, 1'b1, 1'b1);
    pop_check("R5 no parity", {4'b0000, 8'h5A});

    // R6: low stop, then line held low briefly before going high
    cfg_stick = 1'b0;
    send(8'h47, 1'b0, 1'b0, 1'b0);
    rxd = 1'b0;
    wait_ticks(24);
    rxd = 1'b1;
    wait_ticks(16);
    pop_check("R6 framing", {4'b0001, 8'h47});
    check_empty("R6 no extra char");

    // R8: break with stick parity bit 0
    cfg_par_en = 1'b1; cfg_stick = 1'b1; cfg_even = 1'b1;
    send(8'h00, 1'b0, 1'b0, 1'b0);
    rxd = 1'b0;
    wait_ticks(40);
    rxd = 1'b1;
    wait_ticks(16);
    pop_check("R8 break", {4'b0101, 8'h00});
    check_empty("R8 single char");

    // R7: two stop bits configured, next start right after first stop
    cfg_par_en = 1'b0; cfg_stick = 1'b0; cfg_two_stop = 1'b1;
    send(8'h11, 1'b0, 1'b1, 1'b0);
    send(8'h22, 1'b0, 1'b1, 1'b1);
    pop_check("R7 back to back a", {4'b0000, 8'h11});
    pop_check("R7 back to back b", {4'b0000, 8'h22});
    cfg_two_stop = 1'b0;

    // R9 + R11: fill the queue, overflow by one
    for (int i = 0; i <= DEPTH; i++) send(8'(i * 7 + 1), 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < DEPTH; i++) pop_check("R9 order", {4'b0000, 8'(i * 7 + 1)});
    check_empty("R11 discarded");
    send(8'hE1, 1'b0, 1'b1, 1'b1);
    send(8'hE2, 1'b0, 1'b1, 1'b1);
    pop_check("R11 overrun flag", {4'b1000, 8'hE1});
    pop_check("R11 flag clears", {4'b0000, 8'hE2});

    // R10: single slot mode
    cfg_fifo_en = 1'b0;
    send(8'hA1, 1'b0, 1'b1, 1'b1);
    send(8'hA2, 1'b0, 1'b1, 1'b1);
    pop_check("R10 held", {4'b0000, 8'hA1});
    check_empty("R10 one slot");
    send(8'hA3, 1'b0, 1'b1, 1'b1);
    pop_check("R10 overrun", {4'b1000, 8'hA3});
    cfg_fifo_en = 1'b1;

    // Random frames queued in batches of 4, then drained
    for (int b = 0; b < 8; b++) begin
      exp_q.delete();
      cfg_wlen   = 2'($urandom_range(0, 3));
      cfg_par_en = 1'($urandom_range(0, 1));
      cfg_even   = 1'($urandom_range(0, 1));
      cfg_stick  = 1'($urandom_range(0, 1));
      for (int i = 0; i < 4; i++) begin
        logic [7:0] d;
        logic bp, sv;
        d  = 8'($urandom);
        bp = 1'($urandom_range(0, 3) == 0);
        sv = 1'($urandom_range(0, 5) != 0);
        exp_q.push_back(expect_entry(d, bp, sv, 1'b0));
        send(d, bp, sv, 1'b1);
      end
      for (int i = 0; i < 4; i++) pop_check("R1 R3 R4 R5 R6 R9 random", exp_q[i]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule